// File: doc/BRIEF.md
# Dual-Bank Word Access Controller

This block sits between a CPU load/store port and a memory made of two byte-wide banks: one holding the even byte addresses and one holding the odd ones. Each request carries a 20-bit byte address, a byte/word size flag, a direction flag and 16 bits of store data. The block turns each request into one or two bus cycles. For every cycle it drives the word address (address bits 19..1), the address bit 0 line, a high-bank enable and steered write data. It collects the returned lanes into a little-endian result.

On the normal 16-bit bus, an even-addressed word moves in a single cycle with both banks enabled. A word at an odd address is split into two cycles. The first cycle carries the low byte in the odd bank of the containing word. The second cycle carries the high byte in the even bank of the next word, wrapping at the top of the address space. When the narrow-bus input is set, the bus is treated as 8 bits wide. Every byte then travels on the lower lane with the high-bank enable held off, and every word takes two cycles whatever its alignment.

A request is taken only while `ready` is high. `done` pulses for one cycle after the last bus cycle of the access. For loads, `rdata` holds the result while `done` is high.

Top module: `dbw_ctrl`

## Requirements
- R1: After reset, `bus_cyc` and `done` are 0 and `ready` is 1. No bus cycle is ever presented while `ready` is 1.
- R2: A word access at an even address on the 16-bit bus takes exactly one bus cycle with `bus_a0`=0, `bus_hi_en`=1 and `bus_wa`=addr[19:1]. Lane 7..0 is the byte at addr and lane 15..8 is the byte at addr+1.
- R3: A byte access on the 16-bit bus takes one bus cycle. An even byte uses `bus_a0`=0 and `bus_hi_en`=0. An odd byte uses `bus_a0`=1 and `bus_hi_en`=1. An odd byte is read from lane 15..8 and returned in `rdata[7:0]`. A byte load always returns `rdata[15:8]`=0.
- R4: A word access at an odd address on the 16-bit bus takes two bus cycles. The first cycle has `bus_wa`=addr[19:1], `bus_a0`=1 and `bus_hi_en`=1, and carries the low byte. The second cycle has `bus_wa` one higher, `bus_a0`=0 and `bus_hi_en`=0, and carries the high byte. The load result is {second byte, first byte}.
- R5: Byte order is little-endian: a stored word puts bits 7..0 at addr and bits 15..8 at addr+1.
- R6: With `req_narrow`=1, every word access takes two bus cycles. Every byte access takes one. `bus_hi_en` is 0 in all of these cycles. The byte address {bus_wa,bus_a0} is addr in the first cycle and addr+1 in the second. Data moves on lane 7..0.
- R7: `done` is high for exactly one cycle, in the cycle after the last bus cycle. `ready` is 0 from the cycle after a request is accepted until `done`.
- R8: A request raised while `ready` is 0 is ignored: it produces no bus cycle and changes no memory byte.
- R9: The second cycle of a split word at address 0xFFFFF wraps to word address 0 (16-bit bus) or byte address 0 (narrow bus).
- R10: Every bus cycle of a store has `bus_we`=1. A byte store changes only the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when ready is 1 |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_we | input | 1 | 1 = store, 0 = load |
| req_narrow | input | 1 | 1 = 8-bit external bus |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Store data (byte stores use bits 7..0) |
| ready | output | 1 | Idle, a request may be raised |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Load result, valid with done |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_wa | output | 19 | Word address (byte address bits 19..1) |
| bus_a0 | output | 1 | Byte address bit 0; 0 enables the even bank |
| bus_hi_en | output | 1 | Enables the odd bank / upper lane |
| bus_wdata | output | 16 | Write data lanes |
| bus_rdata | input | 16 | Read data lanes, sampled at the end of each bus cycle |

## Verification
The assertions check, on every cycle, the cycle-level rules:
- no bus cycle while idle;
- `done` only right after a bus cycle;
- an aligned wide word finishing after a single cycle;
- the second half of a split access landing one word (or one byte in narrow mode) above the first, with the even bank alone selected on the wide bus;
- the high-bank enable held off in narrow mode.

Only the bench scenarios can show that the data ends up where it belongs. They cover the little-endian placement of stored words, lane swapping on odd bytes and split words, reassembly of loads, untouched neighbour bytes, the wrap at 0xFFFFF and a request ignored while busy. The bench does this by reading memory back through ordinary byte loads.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} dbw_state_e;
  // which data lane(s) a bus cycle uses
  typedef enum logic [1:0] {LN_LOW, LN_HIGH, LN_BOTH} dbw_lane_e;
endpackage

// File: rtl/dbw_plan.sv
module dbw_plan
  import dbw_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_word,
  input  logic              narrow,
  output logic              two_cyc,
  output logic [ADDR_W-2:0] p1_wa,
  output logic              p1_a0,
  output logic              p1_hi,
  output dbw_lane_e         p1_lane,
  output logic [ADDR_W-2:0] p2_wa,
  output logic              p2_a0,
  output logic              p2_hi,
  output dbw_lane_e         p2_lane
);
  logic [ADDR_W-1:0] nxt;

  always_comb begin
    nxt     = addr + 1'b1;              // wraps at the top of the space
    two_cyc = is_word & (narrow | addr[0]);
    p1_wa   = addr[ADDR_W-1:1];
    p1_a0   = addr[0];
    p1_hi   = ~narrow & (is_word | addr[0]);
    if (narrow)                     p1_lane = LN_LOW;
    else if (is_word && !addr[0])   p1_lane = LN_BOTH;
    else if (addr[0])               p1_lane = LN_HIGH;
    else                            p1_lane = LN_LOW;
    // second half always lands on the even bank / lower lane
    p2_wa   = nxt[ADDR_W-1:1];
    p2_a0   = nxt[0];
    p2_hi   = 1'b0;
    p2_lane = LN_LOW;
  end
endmodule

// File: rtl/dbw_wsteer.sv
module dbw_wsteer
  import dbw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  dbw_lane_e           lane,
  input  logic                take_hi,
  input  logic [2*BYTE_W-1:0] wd,
  output logic [2*BYTE_W-1:0] lanes
);
  logic [BYTE_W-1:0] sel;

  always_comb begin
    sel = take_hi ? wd[2*BYTE_W-1:BYTE_W] : wd[BYTE_W-1:0];
    // a single byte is driven on both lanes; the bank enables pick the one used
    lanes = (lane == LN_BOTH) ? wd : {sel, sel};
  end
endmodule

// File: rtl/dbw_rsteer.sv
module dbw_rsteer
  import dbw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  dbw_lane_e           lane,
  input  logic [2*BYTE_W-1:0] lanes,
  output logic [BYTE_W-1:0]   rbyte
);
  always_comb
    rbyte = (lane == LN_HIGH) ? lanes[2*BYTE_W-1:BYTE_W] : lanes[BYTE_W-1:0];
endmodule

// File: rtl/dbw_ctrl.sv
module dbw_ctrl
  import dbw_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                req_word,
  input  logic                req_we,
  input  logic                req_narrow,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic                ready,
  output logic                done,
  output logic [2*BYTE_W-1:0] rdata,
  output logic                bus_cyc,
  output logic                bus_we,
  output logic [ADDR_W-2:0]   bus_wa,
  output logic                bus_a0,
  output logic                bus_hi_en,
  output logic [2*BYTE_W-1:0] bus_wdata,
  input  logic [2*BYTE_W-1:0] bus_rdata
);
  localparam int DATA_W = 2 * BYTE_W;
  localparam int WA_W   = ADDR_W - 1;

  dbw_state_e        state_q;
  dbw_lane_e         lane_q, nxt_lane_q;
  logic              two_q, narrow_q;
  logic [WA_W-1:0]   nxt_wa_q;
  logic              nxt_a0_q, nxt_hi_q;
  logic [DATA_W-1:0] nxt_wdata_q;
  logic [BYTE_W-1:0] lo_q;

  // request decode
  logic              two_cyc, p1_a0, p1_hi, p2_a0, p2_hi;
  logic [WA_W-1:0]   p1_wa, p2_wa;
  dbw_lane_e         p1_lane, p2_lane;

  dbw_plan #(.ADDR_W(ADDR_W)) u_plan (
    .addr(req_addr), .is_word(req_word), .narrow(req_narrow),
    .two_cyc(two_cyc),
    .p1_wa(p1_wa), .p1_a0(p1_a0), .p1_hi(p1_hi), .p1_lane(p1_lane),
    .p2_wa(p2_wa), .p2_a0(p2_a0), .p2_hi(p2_hi), .p2_lane(p2_lane)
  );

  // write lane steering for both phases, prepared at accept time
  dbw_lane_e         ph_lane [2];
  logic [DATA_W-1:0] ph_wdata [2];

  always_comb begin
    ph_lane[0] = p1_lane;
    ph_lane[1] = p2_lane;
  end

  for (genvar ph = 0; ph < 2; ph++) begin : g_wr
    dbw_wsteer #(.BYTE_W(BYTE_W)) u_ws (
      .lane(ph_lane[ph]), .take_hi(ph != 0), .wd(req_wdata), .lanes(ph_wdata[ph])
    );
  end

  // read lane extraction for the active cycle
  logic [BYTE_W-1:0] rd_byte;

  dbw_rsteer #(.BYTE_W(BYTE_W)) u_rs (
    .lane(lane_q), .lanes(bus_rdata), .rbyte(rd_byte)
  );

  assign ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      done        <= 1'b0;
      rdata       <= '0;
      bus_cyc     <= 1'b0;
      bus_we      <= 1'b0;
      bus_wa      <= '0;
      bus_a0      <= 1'b0;
      bus_hi_en   <= 1'b0;
      bus_wdata   <= '0;
      lane_q      <= LN_LOW;
      nxt_lane_q  <= LN_LOW;
      two_q       <= 1'b0;
      narrow_q    <= 1'b0;
      nxt_wa_q    <= '0;
      nxt_a0_q    <= 1'b0;
      nxt_hi_q    <= 1'b0;
      nxt_wdata_q <= '0;
      lo_q        <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req) begin
          state_q     <= ST_FIRST;
          bus_cyc     <= 1'b1;
          bus_we      <= req_we;
          bus_wa      <= p1_wa;
          bus_a0      <= p1_a0;
          bus_hi_en   <= p1_hi;
          bus_wdata   <= ph_wdata[0];
          lane_q      <= p1_lane;
          two_q       <= two_cyc;
          narrow_q    <= req_narrow;
          nxt_wa_q    <= p2_wa;
          nxt_a0_q    <= p2_a0;
          nxt_hi_q    <= p2_hi;
          nxt_lane_q  <= p2_lane;
          nxt_wdata_q <= ph_wdata[1];
        end
        ST_FIRST: begin
          if (lane_q == LN_BOTH) begin
            rdata   <= bus_rdata;
            bus_cyc <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (two_q) begin
            lo_q      <= rd_byte;
            bus_wa    <= nxt_wa_q;
            bus_a0    <= nxt_a0_q;
            bus_hi_en <= nxt_hi_q;
            bus_wdata <= nxt_wdata_q;
            lane_q    <= nxt_lane_q;
            state_q   <= ST_SECOND;
          end else begin
            rdata   <= {{BYTE_W{1'b0}}, rd_byte};
            bus_cyc <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_SECOND: begin
          rdata   <= {rd_byte, lo_q};
          bus_cyc <= 1'b0;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    ready |-> !bus_cyc);

  p_aligned_single_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && state_q == ST_FIRST && !narrow_q && !bus_a0 && bus_hi_en)
      |=> (done && !bus_cyc));

  p_split_even_bank_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SECOND && !narrow_q) |-> (bus_cyc && !bus_a0 && !bus_hi_en));

  p_split_next_word_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SECOND && !narrow_q) |-> (bus_wa == $past(bus_wa) + 1'b1));

  p_narrow_no_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && narrow_q) |-> !bus_hi_en);

  p_narrow_next_byte_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SECOND && narrow_q) |-> ({bus_wa, bus_a0} == $past({bus_wa, bus_a0}) + 1'b1));

  p_done_after_bus_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(bus_cyc) && !bus_cyc));
endmodule

// File: tb/sim_dbw_ctrl.sv
module sim_dbw_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req, req_word, req_we, req_narrow;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        ready, done, bus_cyc, bus_we, bus_a0, bus_hi_en;
  logic [15:0] rdata, bus_wdata, bus_rdata;
  logic [18:0] bus_wa;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbw_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .req_word(req_word), .req_we(req_we),
    .req_narrow(req_narrow), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .done(done), .rdata(rdata), .bus_cyc(bus_cyc), .bus_we(bus_we),
    .bus_wa(bus_wa), .bus_a0(bus_a0), .bus_hi_en(bus_hi_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // byte memory model (low 9 address bits), and the bench's expected copy
  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  logic       mode_narrow = 1'b0;

  always_comb begin
    if (mode_narrow)
      bus_rdata = {8'hEE, mem[{bus_wa[7:0], bus_a0}]};
    else
      bus_rdata = {bus_hi_en ? mem[{bus_wa[7:0], 1'b1}] : 8'hEE,
                   !bus_a0   ? mem[{bus_wa[7:0], 1'b0}] : 8'hEE};
  end

  always @(posedge clk) begin
    if (bus_cyc && bus_we) begin
      if (mode_narrow) mem[{bus_wa[7:0], bus_a0}] <= bus_wdata[7:0];
      else begin
        if (!bus_a0)   mem[{bus_wa[7:0], 1'b0}] <= bus_wdata[7:0];
        if (bus_hi_en) mem[{bus_wa[7:0], 1'b1}] <= bus_wdata[15:8];
      end
    end
  end

  int n_chk = 0;
  int n_err = 0;

  // per-access record of bus cycles
  logic [18:0] c_wa [2];
  logic        c_a0 [2];
  logic        c_hi [2];
  logic        c_we [2];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic word, input logic we, input logic nar,
                        input logic [19:0] a, input logic [15:0] wd,
                        output logic [15:0] rd, output int n);
    logic [19:0] a1;
    n = 0;
    a1 = a + 20'd1;
    @(negedge clk);
    mode_narrow = nar;
    req = 1'b1; req_word = word; req_we = we; req_narrow = nar;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (done) break;
      if (bus_cyc) begin
        if (n < 2) begin
          c_wa[n] = bus_wa; c_a0[n] = bus_a0; c_hi[n] = bus_hi_en; c_we[n] = bus_we;
        end
        n++;
      end
      chk(!ready, "R7", "ready high while busy", 32'(ready), 32'd0);
      @(negedge clk);
    end
    chk(done, "R7", "done pulse missing", 32'(done), 32'd1);
    rd = rdata;
    @(negedge clk);
    chk(!done, "R7", "done wider than one cycle", 32'(done), 32'd0);
    if (we) begin
      exp_mem[a[8:0]] = wd[7:0];
      if (word) exp_mem[a1[8:0]] = wd[15:8];
    end
  endtask

  task automatic rd_byte_chk(input logic [19:0] a, input logic nar, input string tag);
    logic [15:0] rd;
    int n;
    access(1'b0, 1'b0, nar, a, 16'h0, rd, n);
    chk(n == 1, tag, "byte load cycle count", 32'(n), 32'd1);
    chk(rd == {8'h00, exp_mem[a[8:0]]}, tag, "byte load value", 32'(rd),
        32'({8'h00, exp_mem[a[8:0]]}));
  endtask

  task automatic t_reset;
    chk(!bus_cyc, "R1", "bus_cyc after reset", 32'(bus_cyc), 32'd0);
    chk(!done, "R1", "done after reset", 32'(done), 32'd0);
    chk(ready, "R1", "ready after reset", 32'(ready), 32'd1);
  endtask

  task automatic t_aligned_word;
    logic [15:0] rd;
    int n;
    access(1'b1, 1'b1, 1'b0, 20'h00100, 16'hBEEF, rd, n);
    chk(n == 1, "R2", "aligned store cycles", 32'(n), 32'd1);
    chk(c_wa[0] == 19'h00080, "R2", "aligned word address", 32'(c_wa[0]), 32'h80);
    chk(!c_a0[0] && c_hi[0], "R2", "aligned enables {a0,hi}",
        32'({c_a0[0], c_hi[0]}), 32'b01);
    chk(c_we[0], "R10", "store bus_we", 32'(c_we[0]), 32'd1);
    rd_byte_chk(20'h00100, 1'b0, "R5");   // low byte at lower address
    rd_byte_chk(20'h00101, 1'b0, "R3");   // odd byte from upper lane
    access(1'b1, 1'b0, 1'b0, 20'h00100, 16'h0, rd, n);
    chk(rd == 16'hBEEF, "R2", "aligned word load", 32'(rd), 32'hBEEF);
  endtask

  task automatic t_byte_enables;
    logic [15:0] rd;
    int n;
    access(1'b0, 1'b0, 1'b0, 20'h00040, 16'h0, rd, n);
    chk(!c_a0[0] && !c_hi[0], "R3", "even byte enables", 32'({c_a0[0], c_hi[0]}), 32'b00);
    chk(rd == {8'h00, exp_mem[9'h040]}, "R3", "even byte value", 32'(rd), 32'(exp_mem[9'h040]));
    access(1'b0, 1'b0, 1'b0, 20'h00041, 16'h0, rd, n);
    chk(c_a0[0] && c_hi[0], "R3", "odd byte enables", 32'({c_a0[0], c_hi[0]}), 32'b11);
    chk(rd == {8'h00, exp_mem[9'h041]}, "R3", "odd byte lane swap", 32'(rd), 32'(exp_mem[9'h041]));
  endtask

  task automatic t_misaligned;
    logic [15:0] rd;
    int n;
    access(1'b1, 1'b1, 1'b0, 20'h00203, 16'h1234, rd, n);
    chk(n == 2, "R4", "split store cycles", 32'(n), 32'd2);
    chk(c_wa[0] == 19'h00101 && c_a0[0] && c_hi[0], "R4", "first half {wa,a0,hi}",
        32'({c_wa[0], c_a0[0], c_hi[0]}), 32'({19'h00101, 2'b11}));
    chk(c_wa[1] == 19'h00102 && !c_a0[1] && !c_hi[1], "R4", "second half {wa,a0,hi}",
        32'({c_wa[1], c_a0[1], c_hi[1]}), 32'({19'h00102, 2'b00}));
    chk(c_we[1], "R10", "second half bus_we", 32'(c_we[1]), 32'd1);
    rd_byte_chk(20'h00203, 1'b0, "R5");
    rd_byte_chk(20'h00204, 1'b0, "R5");
    rd_byte_chk(20'h00202, 1'b0, "R10");
    rd_byte_chk(20'h00205, 1'b0, "R10");
    access(1'b1, 1'b0, 1'b0, 20'h00203, 16'h0, rd, n);
    chk(rd == 16'h1234 && n == 2, "R4", "split load value", 32'(rd), 32'h1234);
  endtask

  task automatic t_wrap;
    logic [15:0] rd;
    int n;
    access(1'b1, 1'b1, 1'b0, 20'hFFFFF, 16'hA55A, rd, n);
    chk(c_wa[1] == 19'h0, "R9", "wide wrap word address", 32'(c_wa[1]), 32'd0);
    rd_byte_chk(20'h00000, 1'b0, "R9");
    access(1'b1, 1'b0, 1'b0, 20'hFFFFF, 16'h0, rd, n);
    chk(rd == 16'hA55A, "R9", "wide wrap load", 32'(rd), 32'hA55A);
    access(1'b1, 1'b0, 1'b1, 20'hFFFFF, 16'h0, rd, n);
    chk({c_wa[1], c_a0[1]} == 20'h0, "R9", "narrow wrap byte address",
        32'({c_wa[1], c_a0[1]}), 32'd0);
    chk(rd == 16'hA55A, "R9", "narrow wrap load", 32'(rd), 32'hA55A);
  endtask

  task automatic t_narrow;
    logic [15:0] rd;
    int n;
    access(1'b1, 1'b1, 1'b1, 20'h00301, 16'hC3D2, rd, n);
    chk(n == 2, "R6", "narrow odd word cycles", 32'(n), 32'd2);
    chk({c_wa[0], c_a0[0]} == 20'h00301 && {c_wa[1], c_a0[1]} == 20'h00302, "R6",
        "narrow byte address sequence", 32'({c_wa[1], c_a0[1]}), 32'h00302);
    chk(!c_hi[0] && !c_hi[1], "R6", "narrow hi enable", 32'({c_hi[0], c_hi[1]}), 32'd0);
    access(1'b1, 1'b0, 1'b1, 20'h00300, 16'h0, rd, n);
    chk(n == 2, "R6", "narrow aligned word cycles", 32'(n), 32'd2);
    chk(rd == {exp_mem[9'h101], exp_mem[9'h100]}, "R6", "narrow aligned load", 32'(rd),
        32'({exp_mem[9'h101], exp_mem[9'h100]}));
    access(1'b0, 1'b0, 1'b1, 20'h00301, 16'h0, rd, n);
    chk(n == 1 && !c_hi[0], "R6", "narrow odd byte single cycle", 32'(n), 32'd1);
    chk(rd == 16'h00D2, "R6", "narrow odd byte value", 32'(rd), 32'hD2);
    rd_byte_chk(20'h00302, 1'b0, "R5");
  endtask

  task automatic t_byte_store;
    logic [15:0] rd;
    int n;
    access(1'b0, 1'b1, 1'b0, 20'h00401, 16'hFF77, rd, n);
    chk(n == 1 && c_we[0], "R10", "byte store single write cycle", 32'(n), 32'd1);
    rd_byte_chk(20'h00401, 1'b0, "R10");
    rd_byte_chk(20'h00400, 1'b0, "R10");
    rd_byte_chk(20'h00402, 1'b0, "R10");
  endtask

  task automatic t_busy_ignore;
    int n = 0;
    @(negedge clk);
    mode_narrow = 1'b0;
    req = 1'b1; req_word = 1'b1; req_we = 1'b0; req_narrow = 1'b0;
    req_addr = 20'h00203; req_wdata = 16'h0;
    @(negedge clk);
    // busy now: raise a store that must be dropped
    req = 1'b1; req_word = 1'b0; req_we = 1'b1; req_addr = 20'h00150; req_wdata = 16'h0099;
    for (int k = 0; k < 12; k++) begin
      if (done) break;
      if (bus_cyc) n++;
      @(negedge clk);
      req = 1'b0;
    end
    req = 1'b0;
    chk(n == 2, "R8", "cycles of accepted access", 32'(n), 32'd2);
    chk(rdata == 16'h1234, "R8", "accepted access result", 32'(rdata), 32'h1234);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!bus_cyc, "R8", "bus cycle from ignored request", 32'(bus_cyc), 32'd0);
    end
    rd_byte_chk(20'h00150, 1'b0, "R8");
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    rst = 1'b1; req = 1'b0; req_word = 1'b0; req_we = 1'b0; req_narrow = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_aligned_word();
    t_byte_enables();
    t_misaligned();
    t_wrap();
    t_narrow();
    t_byte_store();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule